// File: doc/BRIEF.md
# 6809E Bus Clock and Memory Glue

This block sits between a master clock and an external-clock 6809-family processor that needs its two bus clocks supplied from outside. A two-bit phase counter splits each bus cycle into four master-clock periods and produces the two quadrature clocks, E and Q. Q leads E by one master period, and both are square waves with 50% duty.

The same block decodes the 16-bit address into a RAM select, a ROM select and a small bank of one-hot peripheral selects. It also produces separate read and write strobes for asynchronous parts. Early-write timing is assumed: the read/not-write line settles before the strobes move data. The read strobe follows that line directly. The write strobe is also gated by Q, so it ends halfway through E-high rather than at the falling edge of E, which leaves a slow memory or peripheral a full quarter cycle of data hold.

Top module: `bus_glue`

## Requirements
- R1: E and Q each have a period of four master clocks and are high for exactly two of them.
- R2: Once reset is released, Q goes high on the first rising master edge and E goes high on the second. Q therefore leads E by one master period, and the high phases are (Q) 1,2 and (E) 2,3 out of 0..3.
- R3: rd_o is high exactly when rnw_i is high and reset is not active.
- R4: wr_o is high exactly when rnw_i is low, reset is not active and Q is high. It therefore falls one master period after E rises, in the middle of E-high.
- R5: ram_cs_o is high for addresses 0x0000 to 0x7FFF.
- R6: rom_cs_o is high for addresses 0xC000 to 0xFFFF.
- R7: For addresses 0xA000 to 0xBFFF, exactly one bit of io_cs_o is high, and its index is addr_i[9:8]. The range 0x8000 to 0x9FFF selects nothing.
- R8: At most one of ram_cs_o, rom_cs_o and the io_cs_o bits is high at any time.
- R9: While rst_ni is low, e_o, q_o, rd_o, wr_o and every select are low, whatever the address and rnw_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock, four per bus cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rnw_i | input | 1 | CPU read/not-write |
| addr_i | input | 16 | CPU address bus |
| e_o | output | 1 | Bus clock E |
| q_o | output | 1 | Quadrature bus clock Q |
| ram_cs_o | output | 1 | RAM select |
| rom_cs_o | output | 1 | ROM select |
| io_cs_o | output | 4 | One-hot peripheral selects |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |

## Verification
The hardest case to reach from the ports is the write strobe ending in the middle of E-high, because it depends on how the phase counter lines up with a write. The bench counts master edges from the release of reset on its own, holds rnw_i low across several whole bus cycles, and compares wr_o with its own model of Q at every phase. The bench also asserts reset in the middle of a write cycle with an I/O address applied. This checks that the clocks, strobes and selects drop at once and that the phase sequence starts again from zero.

// File: rtl/glue_pkg.sv
package glue_pkg;
  typedef enum logic [1:0] {
    REG_RAM  = 2'd0,
    REG_ROM  = 2'd1,
    REG_IO   = 2'd2,
    REG_NONE = 2'd3
  } region_e;
endpackage

// File: rtl/glue_phase.sv
module glue_phase (
  input  logic clk_i,
  input  logic rst_ni,
  output logic e_o,
  output logic q_o
);
  logic [1:0] ph_q, ph_nxt;
  logic       e_q, q_q;

  assign ph_nxt = ph_q + 2'd1;

  // outputs registered from the next phase: glitch-free clocks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= 2'd0;
      e_q  <= 1'b0;
      q_q  <= 1'b0;
    end else begin
      ph_q <= ph_nxt;
      e_q  <= ph_nxt[1];
      q_q  <= ph_nxt[1] ^ ph_nxt[0];
    end
  end

  assign e_o = e_q;
  assign q_o = q_q;

  // R2
  q_leads_e_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_q) |=> $rose(e_q));
  // R1
  e_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(e_q) |=> $stable(e_q));
  // R1
  q_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(q_q) |=> $stable(q_q));
endmodule

// File: rtl/glue_decode.sv
module glue_decode
  import glue_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int NUM_IO     = 4,
  parameter int IO_SEL_LSB = 8,
  localparam int IO_IDX_W  = (NUM_IO > 1) ? $clog2(NUM_IO) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ram_cs_o,
  output logic              rom_cs_o,
  output logic [NUM_IO-1:0] io_cs_o
);
  localparam int TOP = ADDR_W - 1;

  region_e            region;
  logic [IO_IDX_W-1:0] io_idx;
  logic               unused_addr;

  assign unused_addr = ^addr_i;
  assign io_idx      = addr_i[IO_SEL_LSB +: IO_IDX_W];

  always_comb begin
    if (!addr_i[TOP])                         region = REG_RAM;
    else if (addr_i[TOP-1])                   region = REG_ROM;
    else if (addr_i[TOP-2])                   region = REG_IO;
    else                                      region = REG_NONE;
  end

  assign ram_cs_o = rst_ni && (region == REG_RAM);
  assign rom_cs_o = rst_ni && (region == REG_ROM);

  for (genvar i = 0; i < NUM_IO; i++) begin : g_io
    assign io_cs_o[i] = rst_ni && (region == REG_IO) && (io_idx == IO_IDX_W'(i));
  end

  // R8
  one_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_cs_o, rom_cs_o, io_cs_o}));
  // R7
  io_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(io_cs_o));
  // R9
  always_comb begin
    if (!rst_ni) sel_quiet_chk: assert (!ram_cs_o && !rom_cs_o && io_cs_o == '0);
  end
endmodule

// File: rtl/glue_strobe.sv
module glue_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rnw_i,
  input  logic e_i,
  input  logic q_i,
  output logic rd_o,
  output logic wr_o
);
  assign rd_o = rnw_i && rst_ni;
  // Q gate: write ends mid E-high, leaving hold time
  assign wr_o = !rnw_i && rst_ni && q_i;

  // R4
  wr_end_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && e_i) |=> !wr_o);
  // R3
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));
  // R9
  always_comb begin
    if (!rst_ni) strb_quiet_chk: assert (!rd_o && !wr_o);
  end
endmodule

// File: rtl/bus_glue.sv
module bus_glue #(
  parameter int ADDR_W     = 16,
  parameter int NUM_IO     = 4,
  parameter int IO_SEL_LSB = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rnw_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              e_o,
  output logic              q_o,
  output logic              ram_cs_o,
  output logic              rom_cs_o,
  output logic [NUM_IO-1:0] io_cs_o,
  output logic              rd_o,
  output logic              wr_o
);
  logic e_w, q_w;

  glue_phase u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .e_o   (e_w),
    .q_o   (q_w)
  );

  glue_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_IO    (NUM_IO),
    .IO_SEL_LSB(IO_SEL_LSB)
  ) u_decode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .ram_cs_o(ram_cs_o),
    .rom_cs_o(rom_cs_o),
    .io_cs_o (io_cs_o)
  );

  glue_strobe u_strobe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rnw_i (rnw_i),
    .e_i   (e_w),
    .q_i   (q_w),
    .rd_o  (rd_o),
    .wr_o  (wr_o)
  );

  assign e_o = e_w;
  assign q_o = q_w;
endmodule

// File: tb/bus_glue_test.sv
`timescale 1ns/1ps
module bus_glue_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rnw = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic        e, q, ram_cs, rom_cs, rd, wr;
  logic [3:0]  io_cs;
  int          checks = 0, errors = 0;
  int unsigned k = 0;

  always #2.5 clk = ~clk;

  bus_glue uut (
    .clk_i(clk), .rst_ni(rst_n), .rnw_i(rnw), .addr_i(addr),
    .e_o(e), .q_o(q), .ram_cs_o(ram_cs), .rom_cs_o(rom_cs),
    .io_cs_o(io_cs), .rd_o(rd), .wr_o(wr)
  );

  // edges since reset release
  always @(posedge clk or negedge rst_n)
    if (!rst_n) k <= 0; else k <= k + 1;

  function automatic logic exp_q();
    return (k[1:0] == 2'd1) || (k[1:0] == 2'd2);
  endfunction
  function automatic logic exp_e();
    return k[1];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (k=%0d)", tag, act, exp, k);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; addr = 16'hA100; rnw = 1'b0;
    #20;
    chk("R9 clocks in reset", {e, q}, 0);
    chk("R9 strobes in reset", {rd, wr}, 0);
    chk("R9 selects in reset", {ram_cs, rom_cs, io_cs}, 0);
    rnw = 1'b1; addr = 16'h1234;
    #3;
    chk("R9 rd held in reset", rd, 0);
    chk("R9 ram held in reset", ram_cs, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_clocks();
    int e_hi = 0, q_hi = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chk("R2 q phase", q, exp_q());
      chk("R2 e phase", e, exp_e());
      e_hi += e; q_hi += q;
    end
    chk("R1 e duty", e_hi, 8);
    chk("R1 q duty", q_hi, 8);
  endtask

  task automatic t_reads();
    rnw = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R3 rd high on read", rd, 1);
      chk("R4 wr low on read", wr, 0);
    end
    rnw = 1'b0; #1;
    chk("R3 rd follows rnw", rd, 0);
  endtask

  task automatic t_writes();
    logic prev_wr_e;
    rnw = 1'b0;
    prev_wr_e = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R4 wr equals Q", wr, exp_q());
      if (prev_wr_e) chk("R4 wr ends mid E-high", {wr, e}, 2'b01);
      prev_wr_e = wr && e;
    end
    rnw = 1'b1;
  endtask

  task automatic t_decode();
    logic [15:0] a;
    for (int i = 0; i < 16; i++) begin
      a = {i[3:0], 12'h3C5};
      addr = a; #1;
      chk("R5 ram range", ram_cs, a < 16'h8000);
      chk("R6 rom range", rom_cs, a >= 16'hC000);
      if (a >= 16'hA000 && a < 16'hC000)
        chk("R7 io one-hot", io_cs, 4'b0001 << a[9:8]);
      else
        chk("R7 io idle", io_cs, 0);
      chk("R8 single select", $countones({ram_cs, rom_cs, io_cs}) <= 1, 1);
    end
    for (int j = 0; j < 4; j++) begin
      addr = 16'hB000 | 16'(j << 8); #1;
      chk("R7 io index", io_cs, 4'b0001 << j);
    end
    addr = 16'h9F00; #1;
    chk("R7 gap selects nothing", {ram_cs, rom_cs, io_cs}, 0);
    addr = 16'h7FFF; #1; chk("R5 top of ram", ram_cs, 1);
    addr = 16'hBFFF; #1; chk("R7 top of io", io_cs, 4'b1000);
    addr = 16'hC000; #1; chk("R6 rom base", rom_cs, 1);
  endtask

  task automatic t_reset_mid();
    rnw = 1'b0; addr = 16'hA200;
    @(negedge clk); @(negedge clk);
    #1 rst_n = 1'b0; #1;
    chk("R9 async drop", {e, q, rd, wr, ram_cs, rom_cs, io_cs}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R2 restart q", q, 1);
    chk("R2 restart e", e, 0);
    chk("R4 wr after restart", wr, 1);
    chk("R7 io after restart", io_cs, 4'b0100);
  endtask

  initial begin
    t_reset();
    t_clocks();
    t_reads();
    t_writes();
    t_decode();
    t_reset_mid();
    t_clocks();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule